// File: doc/BRIEF.md
# Adaptive Cache-Line Decay Controller

This block decides, for every line of a cache, when the line has been idle long enough that its supply can be gated off to save leakage. A shared slow tick generator advances a small saturating counter kept for each line. Any access or fill to a line clears that line's counter. When a counter reaches its top value on a tick, the line decays: its power enable drops and a one-cycle valid-clear pulse tells the tag logic that the line's contents are gone. An access to a decayed line is reported as a miss. The fill that follows restores power.

In adaptive mode each line also keeps its own decay period, held as a power-of-two multiple of the tick. A line whose decay is followed quickly by a miss was switched off too early, so its period doubles. A line with no miss in that window halves its period. Tag storage, the data array and the next cache level are outside this block.

Access and fill are single-cycle strobes with a line index. They are always accepted, so there is no ready signal and no back-pressure. A strobe is consumed on the clock edge where its valid is high. The miss report is a one-cycle pulse with no handshake, and the consumer must take it in that cycle.

Top module: `cache_decay_ctrl`

## Requirements
- R1: After reset every line is powered, every counter is zero, `line_vld_clr` and `miss_vld` are low, and every line's period exponent is 0 (multiplier 1).
- R2: Counter steps happen only on clock edges numbered k*TICK_PERIOD (k >= 1), with edges counted from the release of reset.
- R3: Each line counter is CNT_W bits wide (2 by default) and clears on an access or fill to that line. A line last touched at edge a, in non-adaptive mode, decays at edge (floor(a/TICK_PERIOD)+3)*TICK_PERIOD. At that edge `line_pwr_en` goes low and `line_vld_clr` is high for exactly the one following cycle.
- R4: When an access and a tick step land on the same line at the same edge, the access wins and the counter ends at zero, so the decay edge follows the R3 formula with a a multiple of TICK_PERIOD.
- R5: A decayed line ignores ticks. Its power stays low and it raises no further `line_vld_clr` until a fill.
- R6: An access to an unpowered line sets `miss_vld` high for one cycle, starting at the edge after the access, with `miss_idx` equal to the accessed index, and the line stays unpowered. An access to a powered line produces no miss. An access made in the same cycle as a fill to the same line also produces no miss.
- R7: A fill powers its line from the fill edge onward and restarts the decay timing from that edge.
- R8: With `adapt_en` high, a line with exponent e (0..3) advances its counter once every 2^e ticks and decays at edge (floor(a/TICK_PERIOD)+3*2^e)*TICK_PERIOD. With `adapt_en` low the multiplier is 1 and exponents do not change.
- R9: In adaptive mode, an access to a decayed line at or before the first tick edge after its decay raises that line's exponent by 1, saturating at 3.
- R10: In adaptive mode, if no access arrives by the first tick edge after a decay, that line's exponent drops by 1, saturating at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adapt_en | input | 1 | Enables per-line period adaptation |
| acc_vld | input | 1 | Access strobe |
| acc_idx | input | IDX_W | Line index of the access |
| fill_vld | input | 1 | Fill strobe |
| fill_idx | input | IDX_W | Line index of the fill |
| line_pwr_en | output | NUM_LINES | Per-line supply enable |
| line_vld_clr | output | NUM_LINES | One-cycle per-line valid-clear at decay |
| miss_vld | output | 1 | Access hit an unpowered line |
| miss_idx | output | IDX_W | Index of the missing line |

## Verification
Power-down and the valid-clear pulse are registered at the tick edge that saturates the counter. The bench therefore computes that edge from the touch edge and the line's current multiplier. It samples the outputs at the falling edge just before and just after that rising edge, and once more a cycle later to confirm the pulse has ended. A miss pulse is due one edge after its access, and a fill takes effect on its own edge, so both are checked at the next falling edge. Exponent changes cannot be seen at the ports directly. They are observed through the length of the next decay interval, which is 3, 6, 12 or 24 ticks.

// File: rtl/cache_decay_pkg.sv
package cache_decay_pkg;

  // Outcome of the adaptive window that opens when a line decays.
  typedef enum logic [1:0] {
    ADJ_KEEP   = 2'd0,
    ADJ_GROW   = 2'd1,
    ADJ_SHRINK = 2'd2
  } period_adj_e;

endpackage

// File: rtl/decay_tick_gen.sv
module decay_tick_gen #(
  parameter int TICK_PERIOD = 2500
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_PERIOD > 1) ? $clog2(TICK_PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/decay_line.sv
module decay_line
  import cache_decay_pkg::*;
#(
  parameter int CNT_W    = 2,
  parameter int EXP_W    = 2,
  parameter int INIT_EXP = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic touch,
  input  logic fill,
  input  logic adapt_en,
  output logic pwr_en,
  output logic vld_clr,
  output logic miss_hit
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int PRE_W   = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic              on_q;
  logic              vclr_q;
  logic              watch_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  pre_lim;
  logic [EXP_W-1:0]  exp_q;
  logic              step;
  logic              adv;
  logic              decay_now;
  period_adj_e       adj;

  always_comb begin
    pre_lim = '0;
    if (adapt_en) pre_lim = PRE_W'((1 << exp_q) - 1);
    // A touch in the same cycle as a tick wins over the tick.
    step      = tick && on_q && !touch && !fill;
    adv       = step && (pre_q == pre_lim);
    decay_now = adv && (cnt_q == CNT_W'(CNT_MAX - 1));
    adj = ADJ_KEEP;
    if (adapt_en && watch_q && !fill) begin
      if (touch)     adj = ADJ_GROW;
      else if (tick) adj = ADJ_SHRINK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q    <= 1'b1;
      vclr_q  <= 1'b0;
      watch_q <= 1'b0;
      cnt_q   <= '0;
      pre_q   <= '0;
      exp_q   <= EXP_W'(INIT_EXP);
    end else begin
      vclr_q <= decay_now;
      if (fill) begin
        on_q  <= 1'b1;
        cnt_q <= '0;
        pre_q <= '0;
      end else if (touch && on_q) begin
        cnt_q <= '0;
        pre_q <= '0;
      end else if (adv) begin
        pre_q <= '0;
        cnt_q <= cnt_q + 1'b1;
        if (decay_now) on_q <= 1'b0;
      end else if (step) begin
        pre_q <= pre_q + 1'b1;
      end

      if (decay_now)                  watch_q <= 1'b1;
      else if (fill || touch || tick) watch_q <= 1'b0;

      case (adj)
        ADJ_GROW:   if (exp_q != EXP_W'(EXP_MAX)) exp_q <= exp_q + 1'b1;
        ADJ_SHRINK: if (exp_q != '0)              exp_q <= exp_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign pwr_en   = on_q;
  assign vld_clr  = vclr_q;
  assign miss_hit = touch && !on_q && !fill;
endmodule

// File: rtl/decay_miss_report.sv
module decay_miss_report #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] line_miss,
  input  logic [IDX_W-1:0]     acc_idx,
  output logic                 miss_vld,
  output logic [IDX_W-1:0]     miss_idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      miss_vld <= 1'b0;
      miss_idx <= '0;
    end else begin
      miss_vld <= |line_miss;
      miss_idx <= acc_idx;
    end
  end
endmodule

// File: rtl/cache_decay_ctrl.sv
module cache_decay_ctrl #(
  parameter int NUM_LINES   = 8,
  parameter int TICK_PERIOD = 2500,
  parameter int CNT_W       = 2,
  parameter int EXP_W       = 2,
  parameter int INIT_EXP    = 0,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 adapt_en,
  input  logic                 acc_vld,
  input  logic [IDX_W-1:0]     acc_idx,
  input  logic                 fill_vld,
  input  logic [IDX_W-1:0]     fill_idx,
  output logic [NUM_LINES-1:0] line_pwr_en,
  output logic [NUM_LINES-1:0] line_vld_clr,
  output logic                 miss_vld,
  output logic [IDX_W-1:0]     miss_idx
);
  logic                 tick;
  logic [NUM_LINES-1:0] line_miss;

  decay_tick_gen #(.TICK_PERIOD(TICK_PERIOD)) tick_i (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic touch_g;
    logic fill_g;
    assign touch_g = acc_vld  && (acc_idx  == IDX_W'(g));
    assign fill_g  = fill_vld && (fill_idx == IDX_W'(g));

    decay_line #(
      .CNT_W    (CNT_W),
      .EXP_W    (EXP_W),
      .INIT_EXP (INIT_EXP)
    ) line_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .touch    (touch_g),
      .fill     (fill_g),
      .adapt_en (adapt_en),
      .pwr_en   (line_pwr_en[g]),
      .vld_clr  (line_vld_clr[g]),
      .miss_hit (line_miss[g])
    );
  end

  decay_miss_report #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) miss_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_miss (line_miss),
    .acc_idx   (acc_idx),
    .miss_vld  (miss_vld),
    .miss_idx  (miss_idx)
  );
endmodule

// File: rtl/cache_decay_ctrl_chk.sv
module cache_decay_ctrl_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_vld,
  input logic [IDX_W-1:0]     acc_idx,
  input logic                 fill_vld,
  input logic [IDX_W-1:0]     fill_idx,
  input logic [NUM_LINES-1:0] line_pwr_en,
  input logic [NUM_LINES-1:0] line_vld_clr,
  input logic                 miss_vld,
  input logic [IDX_W-1:0]     miss_idx
);
  logic [NUM_LINES-1:0] fill_mask;

  always_comb begin
    fill_mask = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (fill_vld && (fill_idx == IDX_W'(i))) fill_mask[i] = 1'b1;
  end

  // R3: the valid-clear pulse marks exactly the lines that lost power on the previous edge
  assert_vclr_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    line_vld_clr == ($past(line_pwr_en) & ~line_pwr_en));

  // R7: power only returns to a line through a fill
  assert_wake_by_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((~$past(line_pwr_en)) & line_pwr_en & ~$past(fill_mask)) == '0);

  // R6: a miss comes from an access to a line that was unpowered
  assert_miss_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |-> ($past(acc_vld) && !$past(line_pwr_en[acc_idx])));

  // R6: the missing line stays unpowered
  assert_miss_line_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |-> !line_pwr_en[miss_idx]);

  // R4: an access to a powered line keeps it powered across the next edge
  assert_touch_keeps_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld && line_pwr_en[acc_idx]) |=> line_pwr_en[$past(acc_idx)]);
endmodule

bind cache_decay_ctrl cache_decay_ctrl_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_vld      (acc_vld),
  .acc_idx      (acc_idx),
  .fill_vld     (fill_vld),
  .fill_idx     (fill_idx),
  .line_pwr_en  (line_pwr_en),
  .line_vld_clr (line_vld_clr),
  .miss_vld     (miss_vld),
  .miss_idx     (miss_idx)
);

// File: tb/cache_decay_ctrl_tb_top.sv
module cache_decay_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T          = 8;
  localparam int N          = 4;
  localparam int IW         = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          adapt_en = 1'b0;
  logic          acc_vld = 1'b0;
  logic [IW-1:0] acc_idx = '0;
  logic          fill_vld = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic [N-1:0]  pwr;
  logic [N-1:0]  vclr;
  logic          miss_vld;
  logic [IW-1:0] miss_idx;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  cache_decay_ctrl #(.NUM_LINES(N), .TICK_PERIOD(T)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .adapt_en     (adapt_en),
    .acc_vld      (acc_vld),
    .acc_idx      (acc_idx),
    .fill_vld     (fill_vld),
    .fill_idx     (fill_idx),
    .line_pwr_en  (pwr),
    .line_vld_clr (vclr),
    .miss_vld     (miss_vld),
    .miss_idx     (miss_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic wait_cyc(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic do_access(input int idx, output int e);
    e = cyc + 1;
    acc_vld = 1'b1;
    acc_idx = IW'(idx);
    @(negedge clk);
    acc_vld = 1'b0;
    acc_idx = '0;
  endtask

  task automatic do_fill(input int idx, output int e);
    e = cyc + 1;
    fill_vld = 1'b1;
    fill_idx = IW'(idx);
    @(negedge clk);
    fill_vld = 1'b0;
    fill_idx = '0;
  endtask

  task automatic align(input int off);
    while (((cyc + 1) % T) != off) @(negedge clk);
  endtask

  function automatic int decay_edge(input int a, input int m);
    return (a / T + 3 * m) * T;
  endfunction

  task automatic chk_decay(input int ln, input int d, input string req);
    wait_cyc(d - 1);
    chk(pwr[ln] == 1'b1, req, int'(pwr[ln]), 1);
    wait_cyc(d);
    chk(pwr[ln] == 1'b0 && vclr[ln] == 1'b1, req, int'({pwr[ln], vclr[ln]}), 1);
    wait_cyc(d + 1);
    chk(vclr[ln] == 1'b0, req, int'(vclr[ln]), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int e;
    int f;
    int d;
    bit ok;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pwr == '1 && vclr == '0 && miss_vld == 1'b0, "R1", int'({pwr, vclr, miss_vld}), 9'h1e0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pwr == '1 && vclr == '0, "R1", int'(pwr), 15);

    // R2/R3: untouched lines decay together at edge 3*T
    wait_cyc(3 * T - 1);
    chk(pwr == '1, "R2", int'(pwr), 15);
    wait_cyc(3 * T);
    chk(pwr == '0 && vclr == '1, "R3", int'({pwr, vclr}), 15);
    wait_cyc(3 * T + 1);
    chk(vclr == '0, "R3", int'(vclr), 0);

    // R5: decayed lines ignore further ticks
    ok = 1'b1;
    for (int k = 0; k < 4 * T; k++) begin
      @(negedge clk);
      if (vclr != '0 || pwr != '0) ok = 1'b0;
    end
    chk(ok, "R5", int'({pwr, vclr}), 0);

    // R6: access to a decayed line reports a miss and leaves it off
    do_access(1, e);
    chk(miss_vld == 1'b1 && miss_idx == 2'd1, "R6", int'({miss_vld, miss_idx}), 5);
    chk(pwr[1] == 1'b0, "R6", int'(pwr[1]), 0);
    @(negedge clk);
    chk(miss_vld == 1'b0, "R6", int'(miss_vld), 0);

    // R3/R4/R7: sweep the access phase across the tick interval
    for (int off = 0; off < T; off++) begin
      do_fill(0, f);
      chk(pwr[0] == 1'b1, "R7", int'(pwr[0]), 1);
      align(off);
      do_access(0, e);
      chk(miss_vld == 1'b0, "R6", int'(miss_vld), 0);
      chk_decay(0, decay_edge(e, 1), (off == 0) ? "R4" : "R3");
    end

    // R3: regular accesses keep a line powered
    do_fill(1, f);
    ok = 1'b1;
    for (int k = 0; k < 6; k++) begin
      repeat (T - 1) begin
        @(negedge clk);
        if (!pwr[1]) ok = 1'b0;
      end
      do_access(1, e);
      if (!pwr[1]) ok = 1'b0;
    end
    chk(ok, "R3", int'(pwr[1]), 1);
    chk_decay(1, decay_edge(e, 1), "R3");

    // R6/R7: fill and access to the same decayed line in one cycle
    fill_vld = 1'b1; fill_idx = 2'd3;
    acc_vld  = 1'b1; acc_idx  = 2'd3;
    @(negedge clk);
    fill_vld = 1'b0; acc_vld = 1'b0;
    chk(miss_vld == 1'b0, "R6", int'(miss_vld), 0);
    chk(pwr[3] == 1'b1, "R7", int'(pwr[3]), 1);

    // R8/R9: quick misses double the period up to 8 ticks
    adapt_en = 1'b1;
    for (int k = 0; k < 5; k++) begin
      do_fill(2, f);
      d = decay_edge(f, 1 << ((k < 3) ? k : 3));
      chk_decay(2, d, (k < 4) ? "R9" : "R8");
      do_access(2, e);
      chk(miss_vld == 1'b1 && miss_idx == 2'd2, "R9", int'({miss_vld, miss_idx}), 6);
    end

    // R8: adaptation off means multiplier 1 and a frozen exponent
    adapt_en = 1'b0;
    do_fill(2, f);
    d = decay_edge(f, 1);
    chk_decay(2, d, "R8");
    do_access(2, e);
    @(negedge clk);
    adapt_en = 1'b1;

    // R10: decays without a following miss halve the period down to 1 tick
    for (int j = 0; j < 5; j++) begin
      do_fill(2, f);
      d = decay_edge(f, 1 << ((3 - j > 0) ? 3 - j : 0));
      chk_decay(2, d, "R10");
      wait_cyc(d + T + 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule